// File: doc/BRIEF.md
# PCI Resource Allocation Engine

This block hands out bus resources to PCI functions as a platform registers them one after another. A device request creates a new function entry; its index is the running device count, and when it asks for one it gets the next interrupt line from a fixed list of ten. A BAR request attaches a memory or I/O base address region to a function that already exists. Every region of one type has the same fixed size, and each type is carved from its own window by a pointer that only moves forward. The encoded BAR word is written into a per-function slot and can be read back through a configuration-dword read port.

Every accepted request gets a done pulse one cycle later, with an error flag, the assigned value and the index. A failed request changes no state. Resources are never freed or shared. On leaving reset the engine uses one cycle to register function 0, a host bridge with no interrupt. During that cycle both request ports report not ready.

Top module: `pra_alloc_top`

## Requirements
- R1: While reset is high and for the first cycle after it falls, `dev_ready` and `bar_ready` are 0. In that first cycle function 0 is registered without an interrupt and without a done pulse, and both window pointers start at their base values.
- R2: A request accepted at a clock edge (valid and ready both high) gives exactly one `rsp_done` pulse, visible after the next edge. With no accepted request, `rsp_done` stays 0.
- R3: A device request succeeds with `rsp_index` equal to the device count before the request. It fails once the count equals `MAX_DEV`.
- R4: Devices that need an interrupt take lines in the order 3, 5, 6, 7, 9, 10, 11, 12, 14, 15, and the line is returned in `rsp_value`. Once all ten are used, a request that needs an interrupt fails, while a request that needs none still succeeds with `rsp_value` 0xFF.
- R5: `irq_q_line` is the line assigned to function `irq_q_dev`. It is 0xFF when that function has no interrupt or is not registered.
- R6: A BAR request fails when `bar_dev` is not below the device count, or when that function already holds six BARs.
- R7: A memory BAR succeeds with `rsp_value` equal to the memory pointer, and the pointer then advances by `MEM_STEP`. The request fails once the pointer has reached `MEM_END`.
- R8: An I/O BAR succeeds with `rsp_value` equal to the I/O pointer, and the pointer then advances by `IO_STEP`. The request fails once the pointer has reached `IO_END`. The stored BAR word has bit 0 set.
- R9: BAR slot n of a function, numbered in the order its BARs were added (`rsp_index` = n), reads back on `cfg_data` at dword index 4+n (byte offset 0x10+4n). Empty slots and dword indices outside 4..9 read 0.
- R10: When both valids are high together, the device request wins. `bar_ready` is 0 in that cycle and the BAR request has no effect.
- R11: A failed request returns `rsp_err`=1 with `rsp_value` and `rsp_index` both 0, and it consumes no interrupt line, pointer space or slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_valid | input | 1 | Device request pulse |
| dev_need_irq | input | 1 | The new function needs an interrupt line |
| dev_ready | output | 1 | Device port can accept a request |
| bar_valid | input | 1 | BAR request pulse |
| bar_dev | input | CNT_W | Target function index |
| bar_is_io | input | 1 | 1 = I/O BAR, 0 = memory BAR |
| bar_ready | output | 1 | BAR port can accept a request |
| rsp_done | output | 1 | Response pulse |
| rsp_err | output | 1 | Request rejected |
| rsp_value | output | 32 | Interrupt line (0xFF if none) or base address |
| rsp_index | output | 8 | New function index or BAR slot number |
| irq_q_dev | input | CNT_W | Function whose interrupt line is queried |
| irq_q_line | output | 8 | Queried line or 0xFF |
| cfg_dev | input | CNT_W | Function whose configuration dword is read |
| cfg_dword | input | 4 | Configuration dword index |
| cfg_data | output | 32 | Configuration dword contents |

## Verification
The bench uses up all ten interrupt lines and then sends one request that needs an interrupt, which must fail, and one that needs none, which must pass. A design that counted lines wrongly would either hand out a line past the end of the list or refuse plain devices. It fills one function to six BARs while memory space is still left, then spends exactly that leftover space on a second function. This shows that a slot-limit failure consumes no space; an engine that advanced the pointer on failure would return a wrong later base. It also sends a device request and a BAR request in the same cycle and checks that the BAR slot stays empty, and it probes function indices at the count and beyond it for both BAR requests and interrupt queries.

// File: rtl/pra_pkg.sv
package pra_pkg;

    localparam int NUM_IRQ    = 10;
    localparam int IRQ_IDX_W  = $clog2(NUM_IRQ + 1);
    localparam int BAR_SLOTS  = 6;
    localparam int SLOT_W     = $clog2(BAR_SLOTS + 1);
    localparam int BAR_DWORD0 = 4;
    localparam logic [7:0] NO_IRQ = 8'hFF;

    typedef struct packed {
        logic        done;
        logic        err;
        logic [31:0] value;
        logic [7:0]  index;
    } rsp_t;

    // Interrupt line handed out for the n-th request needing one.
    function automatic logic [7:0] irq_line(input logic [IRQ_IDX_W-1:0] n);
        case (n)
            4'd0:    irq_line = 8'd3;
            4'd1:    irq_line = 8'd5;
            4'd2:    irq_line = 8'd6;
            4'd3:    irq_line = 8'd7;
            4'd4:    irq_line = 8'd9;
            4'd5:    irq_line = 8'd10;
            4'd6:    irq_line = 8'd11;
            4'd7:    irq_line = 8'd12;
            4'd8:    irq_line = 8'd14;
            4'd9:    irq_line = 8'd15;
            default: irq_line = NO_IRQ;
        endcase
    endfunction

    function automatic logic is_irq_line(input logic [7:0] v);
        is_irq_line = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++)
            if (irq_line(IRQ_IDX_W'(i)) == v) is_irq_line = 1'b1;
    endfunction

endpackage

// File: rtl/pra_window.sv
// Bump-pointer carver for one address window.
module pra_window #(
    parameter logic [31:0] BASE  = 32'h0,
    parameter logic [31:0] STEP  = 32'h100,
    parameter logic [31:0] LIMIT = 32'h1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    output logic [31:0] ptr,
    output logic        avail
);
    assign avail = (ptr < LIMIT);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= BASE;
        else if (take && avail)
            ptr <= ptr + STEP;
    end
endmodule

// File: rtl/pra_irq_pool.sv
// Hands out interrupt lines from the fixed list in order.
module pra_irq_pool
    import pra_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    output logic [7:0] line,
    output logic       avail
);
    logic [IRQ_IDX_W-1:0] next_q;

    assign avail = (next_q < IRQ_IDX_W'(NUM_IRQ));
    assign line  = irq_line(next_q);

    always_ff @(posedge clk) begin
        if (rst)
            next_q <= '0;
        else if (take && avail)
            next_q <= next_q + 1'b1;
    end
endmodule

// File: rtl/pra_dev_table.sv
// Per-function state: interrupt assignment, BAR count and BAR words.
module pra_dev_table
    import pra_pkg::*;
#(
    parameter int MAX_DEV = 12,
    parameter int CNT_W   = $clog2(MAX_DEV + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              add_dev,
    input  logic              add_irq_en,
    input  logic [7:0]        add_irq_line,
    input  logic              add_bar,
    input  logic [CNT_W-1:0]  bar_dev,
    input  logic [31:0]       bar_word,
    output logic [CNT_W-1:0]  dev_count,
    output logic [SLOT_W-1:0] sel_bar_cnt,
    input  logic [CNT_W-1:0]  q_irq_dev,
    output logic [7:0]        q_irq_line,
    input  logic [CNT_W-1:0]  q_cfg_dev,
    input  logic [3:0]        q_cfg_idx,
    output logic [31:0]       q_cfg_data
);
    logic [CNT_W-1:0]  count_q;
    logic              irq_en_q  [MAX_DEV];
    logic [7:0]        irq_ln_q  [MAX_DEV];
    logic [SLOT_W-1:0] bar_cnt_q [MAX_DEV];
    logic [31:0]       bar_q     [MAX_DEV][BAR_SLOTS];

    assign dev_count = count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (add_dev)
            count_q <= count_q + 1'b1;
    end

    for (genvar d = 0; d < MAX_DEV; d++) begin : g_dev
        logic dev_hit, bar_hit;
        assign dev_hit = add_dev && (count_q == CNT_W'(d));
        assign bar_hit = add_bar && (bar_dev == CNT_W'(d));

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_en_q[d]  <= 1'b0;
                irq_ln_q[d]  <= NO_IRQ;
                bar_cnt_q[d] <= '0;
            end else begin
                if (dev_hit) begin
                    irq_en_q[d] <= add_irq_en;
                    irq_ln_q[d] <= add_irq_en ? add_irq_line : NO_IRQ;
                end
                if (bar_hit)
                    bar_cnt_q[d] <= bar_cnt_q[d] + 1'b1;
            end
        end

        for (genvar s = 0; s < BAR_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    bar_q[d][s] <= '0;
                else if (bar_hit && bar_cnt_q[d] == SLOT_W'(s))
                    bar_q[d][s] <= bar_word;
            end
        end
    end

    always_comb begin
        sel_bar_cnt = '0;
        q_irq_line  = NO_IRQ;
        q_cfg_data  = '0;
        for (int d = 0; d < MAX_DEV; d++) begin
            if (bar_dev == CNT_W'(d))
                sel_bar_cnt = bar_cnt_q[d];
            if (q_irq_dev == CNT_W'(d) && irq_en_q[d])
                q_irq_line = irq_ln_q[d];
            if (q_cfg_dev == CNT_W'(d))
                for (int s = 0; s < BAR_SLOTS; s++)
                    if (q_cfg_idx == 4'(BAR_DWORD0 + s))
                        q_cfg_data = bar_q[d][s];
        end
    end
endmodule

// File: rtl/pra_alloc_top.sv
module pra_alloc_top
    import pra_pkg::*;
#(
    parameter int          MAX_DEV  = 12,
    parameter logic [31:0] MEM_BASE = 32'h8000_0000,
    parameter logic [31:0] MEM_STEP = 32'h0001_0000,
    parameter logic [31:0] MEM_END  = 32'h8008_0000,
    parameter logic [31:0] IO_BASE  = 32'h0000_1000,
    parameter logic [31:0] IO_STEP  = 32'h0000_0100,
    parameter logic [31:0] IO_END   = 32'h0000_1300,
    localparam int         CNT_W    = $clog2(MAX_DEV + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_valid,
    input  logic             dev_need_irq,
    output logic             dev_ready,
    input  logic             bar_valid,
    input  logic [CNT_W-1:0] bar_dev,
    input  logic             bar_is_io,
    output logic             bar_ready,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [31:0]      rsp_value,
    output logic [7:0]       rsp_index,
    input  logic [CNT_W-1:0] irq_q_dev,
    output logic [7:0]       irq_q_line,
    input  logic [CNT_W-1:0] cfg_dev,
    input  logic [3:0]       cfg_dword,
    output logic [31:0]      cfg_data
);
    logic init_q;
    rsp_t rsp_q, rsp_d;

    logic [CNT_W-1:0]  dev_count;
    logic [SLOT_W-1:0] sel_bar_cnt;
    logic [31:0]       mem_ptr, io_ptr;
    logic              mem_avail, io_avail;
    logic [7:0]        irq_next;
    logic              irq_avail;

    logic dev_go, bar_go, dev_ok, bar_ok;
    logic dev_commit, bar_commit, irq_take;
    logic [31:0] bar_base, bar_word;

    // Handshake: device port has priority over the BAR port.
    assign dev_ready = !init_q;
    assign bar_ready = !init_q && !dev_valid;
    assign dev_go    = dev_valid && dev_ready;
    assign bar_go    = bar_valid && bar_ready;

    assign dev_ok = (dev_count < CNT_W'(MAX_DEV)) && (!dev_need_irq || irq_avail);
    assign bar_ok = (bar_dev < dev_count)
                 && (sel_bar_cnt < SLOT_W'(BAR_SLOTS))
                 && (bar_is_io ? io_avail : mem_avail);

    // The init cycle registers the host bridge with no interrupt.
    assign dev_commit = init_q ? !rst : (dev_go && dev_ok);
    assign bar_commit = bar_go && bar_ok;
    assign irq_take   = dev_go && dev_ok && dev_need_irq;

    assign bar_base = bar_is_io ? io_ptr : mem_ptr;
    assign bar_word = bar_is_io ? (io_ptr | 32'h1) : (mem_ptr & ~32'hF);

    pra_window #(.BASE(MEM_BASE), .STEP(MEM_STEP), .LIMIT(MEM_END)) u_mem_win (
        .clk(clk), .rst(rst), .take(bar_commit && !bar_is_io),
        .ptr(mem_ptr), .avail(mem_avail)
    );

    pra_window #(.BASE(IO_BASE), .STEP(IO_STEP), .LIMIT(IO_END)) u_io_win (
        .clk(clk), .rst(rst), .take(bar_commit && bar_is_io),
        .ptr(io_ptr), .avail(io_avail)
    );

    pra_irq_pool u_irq (
        .clk(clk), .rst(rst), .take(irq_take),
        .line(irq_next), .avail(irq_avail)
    );

    pra_dev_table #(.MAX_DEV(MAX_DEV), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst(rst),
        .add_dev(dev_commit),
        .add_irq_en(!init_q && dev_need_irq),
        .add_irq_line(irq_next),
        .add_bar(bar_commit), .bar_dev(bar_dev), .bar_word(bar_word),
        .dev_count(dev_count), .sel_bar_cnt(sel_bar_cnt),
        .q_irq_dev(irq_q_dev), .q_irq_line(irq_q_line),
        .q_cfg_dev(cfg_dev), .q_cfg_idx(cfg_dword), .q_cfg_data(cfg_data)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.done  = dev_go || bar_go;
        if (dev_go) begin
            rsp_d.err = !dev_ok;
            if (dev_ok) begin
                rsp_d.value = dev_need_irq ? {24'h0, irq_next} : {24'h0, NO_IRQ};
                rsp_d.index = 8'(dev_count);
            end
        end else if (bar_go) begin
            rsp_d.err = !bar_ok;
            if (bar_ok) begin
                rsp_d.value = bar_base;
                rsp_d.index = 8'(sel_bar_cnt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= 1'b1;
            rsp_q  <= '0;
        end else begin
            init_q <= 1'b0;
            rsp_q  <= rsp_d;
        end
    end

    assign rsp_done  = rsp_q.done;
    assign rsp_err   = rsp_q.err;
    assign rsp_value = rsp_q.value;
    assign rsp_index = rsp_q.index;
endmodule

// File: rtl/pra_checker.sv
module pra_checker
    import pra_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h0,
    parameter logic [31:0] MEM_END  = 32'h0,
    parameter logic [31:0] IO_BASE  = 32'h0,
    parameter logic [31:0] IO_END   = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic        dev_valid,
    input logic        dev_ready,
    input logic        bar_valid,
    input logic        bar_ready,
    input logic        bar_is_io,
    input logic        rsp_done,
    input logic        rsp_err,
    input logic [31:0] rsp_value,
    input logic [7:0]  irq_q_line
);
    logic accepted;
    assign accepted = (dev_valid && dev_ready) || (bar_valid && bar_ready);

    p_not_ready_after_reset_r1: assert property (@(posedge clk)
        rst |=> !dev_ready && !bar_ready);

    p_done_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
        accepted |=> rsp_done);

    p_done_needs_accept_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(accepted));

    p_line_from_list_r5: assert property (@(posedge clk) disable iff (rst)
        irq_q_line == NO_IRQ || is_irq_line(irq_q_line));

    p_mem_base_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_err && $past(bar_valid && bar_ready && !bar_is_io))
        |-> (rsp_value >= MEM_BASE && rsp_value < MEM_END));

    p_io_base_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_err && $past(bar_valid && bar_ready && bar_is_io))
        |-> (rsp_value >= IO_BASE && rsp_value < IO_END));

    p_bar_held_off_r10: assert property (@(posedge clk) disable iff (rst)
        dev_valid |-> !bar_ready);
endmodule

bind pra_alloc_top pra_checker #(
    .MEM_BASE(MEM_BASE), .MEM_END(MEM_END), .IO_BASE(IO_BASE), .IO_END(IO_END)
) u_pra_checker (
    .clk(clk), .rst(rst),
    .dev_valid(dev_valid), .dev_ready(dev_ready),
    .bar_valid(bar_valid), .bar_ready(bar_ready), .bar_is_io(bar_is_io),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_value(rsp_value),
    .irq_q_line(irq_q_line)
);

// File: tb/tb_pra_alloc_top.sv
module tb_pra_alloc_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXD = 12;
    localparam int CW = 4;
    localparam int SLOTS = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dev_valid = 0, dev_need_irq = 0, bar_valid = 0, bar_is_io = 0;
    logic [CW-1:0] bar_dev = '0, irq_q_dev = '0, cfg_dev = '0;
    logic [3:0] cfg_dword = '0;
    logic dev_ready, bar_ready, rsp_done, rsp_err;
    logic [31:0] rsp_value, cfg_data;
    logic [7:0] rsp_index, irq_q_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    pra_alloc_top dut (
        .clk(clk), .rst(rst),
        .dev_valid(dev_valid), .dev_need_irq(dev_need_irq), .dev_ready(dev_ready),
        .bar_valid(bar_valid), .bar_dev(bar_dev), .bar_is_io(bar_is_io), .bar_ready(bar_ready),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_value(rsp_value), .rsp_index(rsp_index),
        .irq_q_dev(irq_q_dev), .irq_q_line(irq_q_line),
        .cfg_dev(cfg_dev), .cfg_dword(cfg_dword), .cfg_data(cfg_data)
    );

    // Behavioural reference model
    int m_cnt, m_irq_n;
    longint m_mem, m_io;
    int m_irq_of [16];
    int m_bars   [16];
    int m_lines  [10] = '{3, 5, 6, 7, 9, 10, 11, 12, 14, 15};

    logic        exp_done = 0, exp_err = 0;
    logic [31:0] exp_val = 0;
    logic [7:0]  exp_idx = 0;
    string       exp_req = "R2";

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compared on every clock, away from the edge.
    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            chk(rsp_done == exp_done, exp_req, "rsp_done", rsp_done, exp_done);
            if (exp_done) begin
                chk(rsp_err == exp_err, exp_req, "rsp_err", rsp_err, exp_err);
                chk(rsp_value == exp_val, exp_req, "rsp_value", rsp_value, exp_val);
                chk(rsp_index == exp_idx, exp_req, "rsp_index", rsp_index, exp_idx);
            end
        end
    end

    task automatic do_dev(input bit need, input bit with_bar, input string req);
        @(negedge clk);
        dev_valid = 1; dev_need_irq = need;
        if (with_bar) begin
            bar_valid = 1; bar_dev = '0; bar_is_io = 0;
            #1 chk(bar_ready == 1'b0, "R10", "bar_ready", bar_ready, 0);
        end
        exp_req = req; exp_done = 1;
        if (m_cnt < MAXD && (!need || m_irq_n < 10)) begin
            exp_err = 0; exp_idx = 8'(m_cnt);
            if (need) begin
                m_irq_of[m_cnt] = m_lines[m_irq_n];
                exp_val = 32'(m_lines[m_irq_n]);
                m_irq_n++;
            end else begin
                m_irq_of[m_cnt] = 255;
                exp_val = 32'hFF;
            end
            m_cnt++;
        end else begin
            exp_err = 1; exp_val = 0; exp_idx = 0;
        end
        @(negedge clk);
        dev_valid = 0; bar_valid = 0; exp_done = 0;
    endtask

    task automatic do_bar(input int dev, input bit io, input string req);
        bit ok;
        @(negedge clk);
        bar_valid = 1; bar_dev = CW'(dev); bar_is_io = io;
        exp_req = req; exp_done = 1;
        ok = (dev < m_cnt) && (m_bars[dev] < SLOTS) &&
             (io ? (m_io < 64'h1300) : (m_mem < 64'h8008_0000));
        if (ok) begin
            exp_err = 0; exp_idx = 8'(m_bars[dev]);
            exp_val = io ? 32'(m_io) : 32'(m_mem);
            m_bars[dev]++;
            if (io) m_io += 64'h100; else m_mem += 64'h1_0000;
        end else begin
            exp_err = 1; exp_val = 0; exp_idx = 0;
        end
        @(negedge clk);
        bar_valid = 0; exp_done = 0;
    endtask

    task automatic chk_irq(input int dev, input int exp, input string req);
        irq_q_dev = CW'(dev);
        #1 chk(irq_q_line == 8'(exp), req, "irq_q_line", irq_q_line, exp);
    endtask

    task automatic chk_cfg(input int dev, input int dw, input logic [31:0] exp, input string req);
        cfg_dev = CW'(dev); cfg_dword = 4'(dw);
        #1 chk(cfg_data == exp, req, "cfg_data", cfg_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cnt = 0; m_irq_n = 0; m_mem = 64'h8000_0000; m_io = 64'h1000;
        for (int i = 0; i < 16; i++) begin m_irq_of[i] = 255; m_bars[i] = 0; end
        repeat (3) @(negedge clk);
        chk(dev_ready == 0 && bar_ready == 0, "R1", "ready in reset", dev_ready, 0);
        rst = 0;
        #1 chk(dev_ready == 0, "R1", "ready in init cycle", dev_ready, 0);
        @(negedge clk);
        m_cnt = 1;
        chk(dev_ready == 1 && bar_ready == 1, "R1", "ready after init", dev_ready, 1);
        chk_irq(0, 255, "R1");
        chk_irq(5, 255, "R5");
        chk_cfg(0, 4, 32'h0, "R9");

        do_bar(1, 0, "R6");              // function 1 not registered
        do_bar(0, 0, "R7");              // 8000_0000 slot 0 of host bridge
        chk_cfg(0, 4, 32'h8000_0000, "R9");

        for (int i = 0; i < 4; i++) do_dev(1, 0, "R4");
        do_dev(1, 1, "R10");             // index 5 plus a BAR request that must be ignored
        chk_cfg(0, 5, 32'h0, "R10");
        for (int i = 0; i < 5; i++) do_dev(1, 0, "R4");
        do_dev(1, 0, "R4");              // lines exhausted
        do_dev(0, 0, "R4");              // index 11 without a line
        do_dev(0, 0, "R3");              // count at maximum
        chk_irq(1, 3, "R5");
        chk_irq(5, 9, "R5");
        chk_irq(10, 15, "R5");
        chk_irq(11, 255, "R5");
        chk_irq(13, 255, "R5");

        for (int i = 0; i < 6; i++) do_bar(1, 0, "R7");
        do_bar(1, 0, "R6");              // slots full, memory space remains
        do_bar(2, 0, "R11");             // takes 8007_0000: failure consumed nothing
        do_bar(2, 0, "R7");              // memory window end
        for (int i = 0; i < 3; i++) do_bar(2, 1, "R8");
        do_bar(3, 1, "R8");              // I/O window end
        do_bar(12, 1, "R6");
        do_bar(15, 0, "R6");

        chk_cfg(1, 4, 32'h8001_0000, "R9");
        chk_cfg(1, 9, 32'h8006_0000, "R9");
        chk_cfg(2, 6, 32'h0000_1101, "R8");
        chk_cfg(2, 7, 32'h0000_1201, "R8");
        chk_cfg(2, 3, 32'h0, "R9");
        chk_cfg(1, 10, 32'h0, "R9");
        chk_cfg(3, 4, 32'h0, "R11");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule